// File: doc/BRIEF.md
# Instruction Boundary Walker

This block walks through the machine code of an 8-bit processor held in memory and finds where each instruction starts. For every instruction it reads three bytes through a byte-read port that has variable latency. It decodes the opcode into an addressing-mode class and an instruction length, and it emits one record. The record holds the start address, the opcode, the two operand bytes, the mode code, the length, and a destination address. The destination is the resolved target for a relative branch and the following instruction address for every other instruction.

It then moves on to the following instruction, at the start address plus the decoded length. A request gives a start address, or asks to resume where the previous walk stopped, and it gives a count of instructions. A debug monitor uses the record stream to build a listing of ten instructions at a time without doing any byte arithmetic itself.

Top module: `insn_walker`

## Requirements
- R1: After reset `busy`, `memReq` and `recValid` are low. The resume address is 0x0000.
- R2: `recMode` codes are: 0 implied, 1 accumulator, 2 immediate, 3 zero page, 4 zero page X, 5 zero page Y, 6 (zp,X), 7 (zp),Y, 8 (zp), 9 absolute, 10 absolute X, 11 absolute Y, 12 (abs), 13 (abs,X), 14 relative. Examples: 0x00→0, 0x0A→1, 0xA0→2, 0x05→3, 0x34→4, 0x96→5, 0x61→6, 0xB1→7, 0x12→8, 0x4C→9, 0x3C→10, 0xBE→11, 0x6C→12, 0x7C→13, 0x10/0x80/0xF0→14. Unassigned opcodes such as 0x03 give 0.
- R3: `recLen` is 1 for modes 0–1, 2 for modes 2–8 and 14, and 3 for modes 9–13.
- R4: For mode 14, `recDest` is the start address plus 2 plus the sign-extended first operand byte, modulo 2^16.
- R5: `recOpnd` is {byte at A+2, byte at A+1}, so the first operand byte is the low half.
- R6: Each instruction at address A takes exactly three reads, in the order A, A+1, A+2. `memAddr` stays stable while `memReq` is high and `memValid` is low.
- R7: The next instruction starts at A + `recLen`. For modes other than 14, `recDest` equals that address.
- R8: A request with count N emits exactly N records and then drops `busy`. N = 0 emits nothing and performs no read.
- R9: When `reqCont` is high, the walk starts at the address that follows the last record of the previous walk, and `reqAddr` is ignored.
- R10: While `recValid` is high and `recReady` is low, all record fields stay unchanged and no read is issued.
- R11: Every address sum wraps from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqStart | input | 1 | Start a walk; accepted only while idle |
| reqCont | input | 1 | Resume from the last computed address |
| reqAddr | input | 16 | Start address when not resuming |
| reqCount | input | 8 | Number of instructions to walk |
| busy | output | 1 | A walk is in progress |
| memReq | output | 1 | Byte read request |
| memAddr | output | 16 | Byte read address |
| memValid | input | 1 | Read completes this cycle |
| memData | input | 8 | Read data, valid with memValid |
| recValid | output | 1 | Record available |
| recReady | input | 1 | Consumer accepts the record |
| recAddr | output | 16 | Instruction start address |
| recOp | output | 8 | Opcode |
| recOpnd | output | 16 | Operand bytes, high:low |
| recMode | output | 4 | Addressing-mode code |
| recLen | output | 2 | Instruction length in bytes |
| recDest | output | 16 | Branch target or next address |

## Verification
A wrong fetch index or a wrong program counter appears at once in the read-address sequence: the read immediately after the fault goes to the wrong byte. One record later it also appears as a shifted start address. A decode error changes `recMode`, `recLen` or `recDest` in the same record. Because addresses are chained, the error then shifts every later record of the walk. A wrong remaining-count register shows up as a wrong number of records, or as `busy` staying high. A branch-target error is confined to the destination field of branch records.

// File: rtl/walker_pkg.sv
package walker_pkg;

  typedef enum logic [3:0] {
    M_IMP  = 4'd0,  M_ACC  = 4'd1,  M_IMM  = 4'd2,  M_ZP   = 4'd3,
    M_ZPX  = 4'd4,  M_ZPY  = 4'd5,  M_ZIX  = 4'd6,  M_ZIY  = 4'd7,
    M_ZIND = 4'd8,  M_ABS  = 4'd9,  M_ABX  = 4'd10, M_ABY  = 4'd11,
    M_AIND = 4'd12, M_AIX  = 4'd13, M_REL  = 4'd14
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // take a new start address
    logic capture;  // store the byte returned by memory
    logic advance;  // step to the following instruction
  } dp_ctl_t;

  function automatic logic [1:0] modeLen(mode_e m);
    case (m)
      M_IMP, M_ACC:                          modeLen = 2'd1;
      M_ABS, M_ABX, M_ABY, M_AIND, M_AIX:    modeLen = 2'd3;
      default:                               modeLen = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/walker_decode.sv
module walker_decode
  import walker_pkg::*;
(
  input  logic [7:0] opcode,
  output mode_e      mode,
  output logic [1:0] len
);
  logic [3:0] hi;
  logic [3:0] lo;
  logic       odd;

  assign hi  = opcode[7:4];
  assign lo  = opcode[3:0];
  assign odd = opcode[4];

  always_comb begin
    mode = M_IMP;
    case (lo)
      4'h0: begin
        if (odd || hi == 4'h8)                       mode = M_REL;
        else if (hi == 4'h2)                         mode = M_ABS;
        else if (hi == 4'hA || hi == 4'hC || hi == 4'hE) mode = M_IMM;
        else                                         mode = M_IMP;
      end
      4'h1: mode = odd ? M_ZIY : M_ZIX;
      4'h2: begin
        if (odd)              mode = M_ZIND;
        else if (hi == 4'hA)  mode = M_IMM;
        else                  mode = M_IMP;
      end
      4'h4: mode = (hi == 4'h3 || hi == 4'h7 || hi == 4'h9 || hi == 4'hB) ? M_ZPX : M_ZP;
      4'h5: mode = odd ? M_ZPX : M_ZP;
      4'h6: begin
        if (!odd)                        mode = M_ZP;
        else if (hi == 4'h9 || hi == 4'hB) mode = M_ZPY;
        else                             mode = M_ZPX;
      end
      4'h9: mode = odd ? M_ABY : M_IMM;
      4'hA: mode = (hi <= 4'h4 || hi == 4'h6) ? M_ACC : M_IMP;
      4'hC: begin
        if (hi == 4'h6)                  mode = M_AIND;
        else if (hi == 4'h7)             mode = M_AIX;
        else if (hi == 4'h3 || hi == 4'hB) mode = M_ABX;
        else                             mode = M_ABS;
      end
      4'hD: mode = odd ? M_ABX : M_ABS;
      4'hE: begin
        if (!odd)             mode = M_ABS;
        else if (hi == 4'hB)  mode = M_ABY;
        else                  mode = M_ABX;
      end
      default: mode = M_IMP;
    endcase
  end

  assign len = modeLen(mode);

endmodule

// File: rtl/walker_ctrl.sv
module walker_ctrl
  import walker_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqStart,
  input  logic [CW-1:0] reqCount,
  input  logic          memValid,
  input  logic          recReady,
  output logic          memReq,
  output logic          recValid,
  output logic          busy,
  output logic [1:0]    fetchIdx,
  output dp_ctl_t       ctl
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EMIT} state_e;

  state_e        stateQ, stateD;
  logic [CW-1:0] remQ;
  logic [1:0]    idxQ;

  always_comb begin
    stateD   = stateQ;
    ctl      = '0;
    memReq   = 1'b0;
    recValid = 1'b0;
    case (stateQ)
      S_IDLE: begin
        if (reqStart) begin
          ctl.load = 1'b1;
          if (reqCount != '0) stateD = S_FETCH;
        end
      end
      S_FETCH: begin
        memReq = 1'b1;
        if (memValid) begin
          ctl.capture = 1'b1;
          if (idxQ == 2'd2) stateD = S_EMIT;
        end
      end
      S_EMIT: begin
        recValid = 1'b1;
        if (recReady) begin
          ctl.advance = 1'b1;
          stateD = (remQ == CW'(1)) ? S_IDLE : S_FETCH;
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      remQ   <= '0;
      idxQ   <= 2'd0;
    end else begin
      stateQ <= stateD;
      if (ctl.load)    remQ <= reqCount;
      if (ctl.advance) remQ <= remQ - CW'(1);
      if (ctl.capture) idxQ <= (idxQ == 2'd2) ? 2'd0 : idxQ + 2'd1;
    end
  end

  assign busy     = (stateQ != S_IDLE);
  assign fetchIdx = idxQ;

  // a walk only ends right after a record was taken (R8)
  p_end_after_rec_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(recValid && recReady));

  // no read while a record waits (R10)
  p_no_fetch_stall_r10: assert property (@(posedge clk) disable iff (!rstN)
    recValid && !recReady |=> !memReq);

endmodule

// File: rtl/walker_dp.sv
module walker_dp
  import walker_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  dp_ctl_t       ctl,
  input  logic          reqCont,
  input  logic [AW-1:0] reqAddr,
  input  logic [1:0]    fetchIdx,
  input  logic [DW-1:0] memData,
  output logic [AW-1:0] memAddr,
  output logic [AW-1:0] recAddr,
  output logic [DW-1:0] recOp,
  output logic [2*DW-1:0] recOpnd,
  output mode_e         recMode,
  output logic [1:0]    recLen,
  output logic [AW-1:0] recDest
);
  logic [AW-1:0] pcQ;
  logic [DW-1:0] opQ, loQ, hiQ;
  logic [AW-1:0] nextAddr;
  logic [AW-1:0] branchAddr;
  mode_e         mode;
  logic [1:0]    len;

  walker_decode u_dec (
    .opcode (opQ),
    .mode   (mode),
    .len    (len)
  );

  assign nextAddr   = pcQ + AW'(len);
  assign branchAddr = pcQ + AW'(2) + {{(AW-DW){loQ[DW-1]}}, loQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ <= '0;
      opQ <= '0;
      loQ <= '0;
      hiQ <= '0;
    end else begin
      if (ctl.load && !reqCont) pcQ <= reqAddr;
      if (ctl.advance)          pcQ <= nextAddr;
      if (ctl.capture) begin
        case (fetchIdx)
          2'd0:    opQ <= memData;
          2'd1:    loQ <= memData;
          default: hiQ <= memData;
        endcase
      end
    end
  end

  assign memAddr = pcQ + AW'(fetchIdx);
  assign recAddr = pcQ;
  assign recOp   = opQ;
  assign recOpnd = {hiQ, loQ};
  assign recMode = mode;
  assign recLen  = len;
  assign recDest = (mode == M_REL) ? branchAddr : nextAddr;

endmodule

// File: rtl/insn_walker.sv
module insn_walker
  import walker_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqStart,
  input  logic            reqCont,
  input  logic [AW-1:0]   reqAddr,
  input  logic [CW-1:0]   reqCount,
  output logic            busy,
  output logic            memReq,
  output logic [AW-1:0]   memAddr,
  input  logic            memValid,
  input  logic [DW-1:0]   memData,
  output logic            recValid,
  input  logic            recReady,
  output logic [AW-1:0]   recAddr,
  output logic [DW-1:0]   recOp,
  output logic [2*DW-1:0] recOpnd,
  output logic [3:0]      recMode,
  output logic [1:0]      recLen,
  output logic [AW-1:0]   recDest
);
  dp_ctl_t    ctl;
  logic [1:0] fetchIdx;
  mode_e      modeW;

  walker_ctrl #(.CW(CW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqStart (reqStart),
    .reqCount (reqCount),
    .memValid (memValid),
    .recReady (recReady),
    .memReq   (memReq),
    .recValid (recValid),
    .busy     (busy),
    .fetchIdx (fetchIdx),
    .ctl      (ctl)
  );

  walker_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqCont  (reqCont),
    .reqAddr  (reqAddr),
    .fetchIdx (fetchIdx),
    .memData  (memData),
    .memAddr  (memAddr),
    .recAddr  (recAddr),
    .recOp    (recOp),
    .recOpnd  (recOpnd),
    .recMode  (modeW),
    .recLen   (recLen),
    .recDest  (recDest)
  );

  assign recMode = modeW;

  // read address held until served (R6)
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq && $stable(memAddr));

  // record frozen under back-pressure (R10)
  p_rec_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    recValid && !recReady |=> recValid && $stable(recAddr) && $stable(recDest)
                              && $stable(recOp) && $stable(recOpnd));

  // following fetch begins at start plus length (R7)
  p_chain_r7: assert property (@(posedge clk) disable iff (!rstN)
    recValid && recReady |=> !memReq || memAddr == $past(recAddr + AW'(recLen)));

endmodule

// File: tb/sim_insn_walker.sv
`timescale 1ns/1ps
module sim_insn_walker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqStart = 1'b0, reqCont = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqCount = '0;
  logic        busy, memReq, memValid, recValid;
  logic        recReady = 1'b1;
  logic [15:0] memAddr, recAddr, recOpnd, recDest;
  logic [7:0]  memData, recOp;
  logic [3:0]  recMode;
  logic [1:0]  recLen;

  always #4 clk = ~clk;

  insn_walker u0 (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqCont(reqCont),
    .reqAddr(reqAddr), .reqCount(reqCount), .busy(busy),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memData(memData),
    .recValid(recValid), .recReady(recReady), .recAddr(recAddr), .recOp(recOp),
    .recOpnd(recOpnd), .recMode(recMode), .recLen(recLen), .recDest(recDest)
  );

  // memory model: 256 bytes aliased over the address space
  logic [7:0] mem [256];
  int latency = 0;
  int waitCnt = 0;
  assign memValid = memReq && (waitCnt >= latency);
  assign memData  = mem[memAddr[7:0]];

  // logs
  logic [15:0] fLog [64];
  int nF = 0;
  logic [15:0] rA [16], rO [16], rD [16];
  logic [7:0]  rOp [16];
  logic [3:0]  rM [16];
  logic [1:0]  rL [16];
  int nR = 0;
  int holdBad = 0;
  int stallMode = 0;
  int stallCnt = 0;
  logic        wasStalled = 1'b0;
  logic [15:0] snapA, snapD, snapO;

  int errors = 0, checks = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (rstN) begin
      if (memReq && memValid) begin
        if (nF < 64) fLog[nF] <= memAddr;
        nF <= nF + 1;
        waitCnt <= 0;
      end else if (memReq) waitCnt <= waitCnt + 1;
      if (wasStalled && (!recValid || recAddr != snapA || recDest != snapD || recOpnd != snapO || memReq))
        holdBad <= holdBad + 1;
      wasStalled <= recValid && !recReady;
      snapA <= recAddr; snapD <= recDest; snapO <= recOpnd;
      if (recValid && recReady) begin
        if (nR < 16) begin
          rA[nR] <= recAddr; rO[nR] <= recOpnd; rD[nR] <= recDest;
          rOp[nR] <= recOp; rM[nR] <= recMode; rL[nR] <= recLen;
        end
        nR <= nR + 1;
      end
    end
  end

  always @(negedge clk) begin
    stallCnt <= stallCnt + 1;
    recReady <= (stallMode == 0) ? 1'b1 : (stallCnt % 4 == 3);
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic walk(input logic [15:0] a, input bit cont, input logic [7:0] n);
    @(negedge clk);
    nF = 0; nR = 0;
    reqAddr = a; reqCont = cont; reqCount = n; reqStart = 1'b1;
    @(negedge clk);
    reqStart = 1'b0;
    for (int k = 0; k < 3000 && busy; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic expRec(input int i, input logic [15:0] a, input logic [7:0] op,
                        input logic [3:0] m, input logic [1:0] l, input logic [15:0] d,
                        input string tag);
    logic [15:0] a1, a2;
    a1 = a + 16'd1; a2 = a + 16'd2;
    chk({tag, " R7 addr"}, rA[i], a);
    chk({tag, " R2 op"}, {8'h0, rOp[i]}, {8'h0, op});
    chk({tag, " R2 mode"}, {12'h0, rM[i]}, {12'h0, m});
    chk({tag, " R3 len"}, {14'h0, rL[i]}, {14'h0, l});
    chk({tag, " R4/R7 dest"}, rD[i], d);
    chk({tag, " R5 opnd"}, rO[i], {mem[a2[7:0]], mem[a1[7:0]]});
  endtask

  task automatic t_reset();
    chk("R1 busy", {15'h0, busy}, 16'h0);
    chk("R1 memReq", {15'h0, memReq}, 16'h0);
    chk("R1 recValid", {15'h0, recValid}, 16'h0);
  endtask

  task automatic t_listing();
    clearMem();
    mem[8'h10]=8'h00; mem[8'h11]=8'h0A; mem[8'h12]=8'hA0; mem[8'h13]=8'h12;
    mem[8'h14]=8'hBE; mem[8'h15]=8'h34; mem[8'h16]=8'h12;
    mem[8'h17]=8'h6C; mem[8'h18]=8'h00; mem[8'h19]=8'h20;
    mem[8'h1A]=8'h10; mem[8'h1B]=8'hFE; mem[8'h1C]=8'h96; mem[8'h1D]=8'h55;
    mem[8'h1E]=8'h7C; mem[8'h1F]=8'h11; mem[8'h20]=8'h22; mem[8'h21]=8'h03;
    mem[8'h22]=8'hB1; mem[8'h23]=8'h40; mem[8'h24]=8'h80; mem[8'h25]=8'h7F;
    mem[8'h26]=8'h61; mem[8'h27]=8'h33;
    latency = 0; stallMode = 0;
    walk(16'h0010, 1'b0, 8'd10);
    chk("R8 record count", nR[15:0], 16'd10);
    chk("R6 read count", nF[15:0], 16'd30);
    chk("R6 read 0", fLog[0], 16'h0010);
    chk("R6 read 1", fLog[1], 16'h0011);
    chk("R6 read 2", fLog[2], 16'h0012);
    chk("R6 read 3", fLog[3], 16'h0011);
    expRec(0, 16'h0010, 8'h00, 4'd0,  2'd1, 16'h0011, "imp");
    expRec(1, 16'h0011, 8'h0A, 4'd1,  2'd1, 16'h0012, "acc");
    expRec(2, 16'h0012, 8'hA0, 4'd2,  2'd2, 16'h0014, "imm");
    expRec(3, 16'h0014, 8'hBE, 4'd11, 2'd3, 16'h0017, "aby");
    expRec(4, 16'h0017, 8'h6C, 4'd12, 2'd3, 16'h001A, "aind");
    expRec(5, 16'h001A, 8'h10, 4'd14, 2'd2, 16'h001A, "rel back");
    expRec(6, 16'h001C, 8'h96, 4'd5,  2'd2, 16'h001E, "zpy");
    expRec(7, 16'h001E, 8'h7C, 4'd13, 2'd3, 16'h0021, "aix");
    expRec(8, 16'h0021, 8'h03, 4'd0,  2'd1, 16'h0022, "unassigned");
    expRec(9, 16'h0022, 8'hB1, 4'd7,  2'd2, 16'h0024, "ziy");
  endtask

  task automatic t_continue();
    latency = 3;
    walk(16'h0500, 1'b1, 8'd2);  // R9: reqAddr must be ignored
    chk("R9 count", nR[15:0], 16'd2);
    expRec(0, 16'h0024, 8'h80, 4'd14, 2'd2, 16'h00A5, "R9 rel fwd");
    expRec(1, 16'h0026, 8'h61, 4'd6,  2'd2, 16'h0028, "R9 zix");
  endtask

  task automatic t_mix();
    clearMem();
    mem[8'h40]=8'h12; mem[8'h41]=8'h20; mem[8'h42]=8'h3C; mem[8'h43]=8'h00;
    mem[8'h44]=8'h30; mem[8'h45]=8'h34; mem[8'h46]=8'h10; mem[8'h47]=8'h05;
    mem[8'h48]=8'h44;
    latency = 2;
    walk(16'h0040, 1'b0, 8'd4);
    chk("R8 mix count", nR[15:0], 16'd4);
    expRec(0, 16'h0040, 8'h12, 4'd8,  2'd2, 16'h0042, "zind");
    expRec(1, 16'h0042, 8'h3C, 4'd10, 2'd3, 16'h0045, "abx");
    expRec(2, 16'h0045, 8'h34, 4'd4,  2'd2, 16'h0047, "zpx");
    expRec(3, 16'h0047, 8'h05, 4'd3,  2'd2, 16'h0049, "zp");
  endtask

  task automatic t_wrap_stall();
    clearMem();
    mem[8'hFE]=8'h4C; mem[8'hFF]=8'h34; mem[8'h00]=8'h12;
    mem[8'h01]=8'hF0; mem[8'h02]=8'h80;
    latency = 1; stallMode = 1;
    walk(16'hFFFE, 1'b0, 8'd2);
    stallMode = 0;
    chk("R11 count", nR[15:0], 16'd2);
    chk("R11 read wrap", fLog[2], 16'h0000);
    chk("R5 opnd across wrap", rO[0], 16'h1234);
    chk("R10 record held", holdBad[15:0], 16'd0);
    expRec(0, 16'hFFFE, 8'h4C, 4'd9,  2'd3, 16'h0001, "R11 abs");
    expRec(1, 16'h0001, 8'hF0, 4'd14, 2'd2, 16'hFF83, "R11 rel");
  endtask

  task automatic t_zero();
    latency = 0;
    walk(16'h0080, 1'b0, 8'd0);
    chk("R8 zero count records", nR[15:0], 16'd0);
    chk("R8 zero count reads", nF[15:0], 16'd0);
    chk("R8 zero count idle", {15'h0, busy}, 16'h0);
  endtask

  initial begin
    clearMem();
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_listing();
    t_continue();
    t_mix();
    t_wrap_stall();
    t_zero();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule